// File: doc/BRIEF.md
# Open-Drain Shared-Channel Bus Arbiter

This block sits in each device on a shared time-division serial bus whose upstream data line is open-drain, so the line reads 0 whenever any device pulls it low. Once per frame, a single arbitration octet carries a bus-free flag and a 3-bit device address. A device with a request reads the flag. If the bus is free, it shifts its address onto the line, most significant bit first, and compares each bit it reads back. A device that sends a 1 and reads a 0 has met a lower address, so it drops out at once. The device that gets through all three bits owns the shared signalling channel. It holds the flag low in every later frame until its request goes away.

After a successful tenure, the device moves to a lower priority class. It may not contend again until it has seen the flag free in two frames in a row. When nobody requests, the floating line reads all ones. The device programmed with address 7 therefore has the channel by default.

The surrounding logic supplies a frame-start pulse and one strobe per bit slot, and it samples the line into `line_in`. The block counts slots itself and acts only inside the arbitration octet.

Top module: `tic_arbiter`

## Requirements
- R1: The arbitration octet starts at bit slot (CH_IDX*OCT_PER_CH + OCT_PER_CH - 1)*8 after `frame_start`. With the default parameters this is slot 88. It holds 8 slots sent bit 7 first. `drive_low` is 0 in every other slot of the frame.
- R2: The flag is bit 5 of the octet, which is the third slot. The value 1 means free and 0 means occupied. A device starts contending only in a frame where it reads the flag as 1.
- R3: A request is present when `sw_req` or `frame_req` is 1. Either source alone is enough.
- R4: While contending, the device uses address bits 2, 1 and 0, which are the last three slots of the octet. In each of these slots it pulls the line low exactly when its address bit is 0.
- R5: If the device sends a 1 and samples a 0, it stops driving for the rest of the octet. It also raises `lost`, which stays high until the next `frame_start`.
- R6: Among devices that contend in the same frame, the one with the lowest address wins. `granted` rises right after the strobe of the address bit 0 slot.
- R7: While `granted` is 1, the device drives the flag slot low in every frame. `granted` falls only at a `frame_start` that finds no request, and the flag is released in that same frame.
- R8: After `granted` falls, the device contends again only after it has sampled the flag as free in two successive frames. An occupied flag restarts the count. The device does not contend in the frame of the second free sample.
- R9: Address 7 never pulls any address slot low. A device with address 7 that contends alone wins.
- R10: A device that lost keeps its request and contends again in the next frame whose flag reads free.
- R11: After reset, `drive_low`, `granted` and `lost` are 0, and the device drives nothing until the first `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| bit_strobe | input | 1 | One-cycle pulse at the end of each bit slot; the line is sampled here |
| line_in | input | 1 | Sampled level of the open-drain upstream line |
| sw_req | input | 1 | Software request for the signalling channel |
| frame_req | input | 1 | Request from a pending outgoing frame |
| addr | input | 3 | Programmed arbitration address |
| drive_low | output | 1 | Open-drain enable; 1 pulls the line to 0 |
| granted | output | 1 | The device owns the channel |
| lost | output | 1 | The device lost arbitration in the current frame |

## Verification
Two things can happen in the same frame: a holder releases the bus, and other devices contend for it. The holder's falling `granted` frees the flag in exactly the frame where rivals read it. The bench sets this up directly. Three instances share a modelled wired-AND line. The holder clears its request while two others request, and the lower of those two addresses must win in that very frame. Constrained-random request patterns, together with an outside device that sometimes holds the flag low, create many more such collisions with back-off counts in progress. A frame-level model judges every slot's drive and every grant and loss.

// File: rtl/tic_arbiter.sv
`timescale 1ns/1ps
module tic_arbiter #(
  parameter int OCT_PER_CH = 4,
  parameter int CH_IDX     = 2,
  parameter int FLAG_BIT   = 5,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              bit_strobe,
  input  logic              line_in,
  input  logic              sw_req,
  input  logic              frame_req,
  input  logic [ADDR_W-1:0] addr,
  output logic              drive_low,
  output logic              granted,
  output logic              lost
);
  localparam int ARB_BASE = (CH_IDX * OCT_PER_CH + OCT_PER_CH - 1) * 8;
  localparam int CNT_MAX  = ARB_BASE + 8;
  localparam int CW       = $clog2(CNT_MAX + 1);

  logic [CW-1:0] bit_cnt;
  logic [CW-1:0] off;
  logic [2:0]    pos;
  logic [7:0]    addr_ext;
  logic          contend, backoff, free_seen;
  logic          req, in_arb, flag_slot, addr_slot, my_bit;

  assign req       = sw_req | frame_req;
  assign in_arb    = (bit_cnt >= CW'(ARB_BASE)) && (bit_cnt < CW'(CNT_MAX));
  assign off       = bit_cnt - CW'(ARB_BASE);
  assign pos       = 3'd7 - off[2:0];
  assign addr_ext  = 8'(addr);
  assign my_bit    = addr_ext[pos];
  assign flag_slot = in_arb && (pos == 3'(FLAG_BIT));
  assign addr_slot = in_arb && (pos < 3'(ADDR_W));
  assign drive_low = (flag_slot & granted) | (addr_slot & contend & ~my_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= CW'(CNT_MAX);
      granted   <= 1'b0;
      lost      <= 1'b0;
      contend   <= 1'b0;
      backoff   <= 1'b0;
      free_seen <= 1'b0;
    end else if (frame_start) begin
      bit_cnt <= '0;
      lost    <= 1'b0;
      contend <= 1'b0;
      if (granted && !req) begin
        granted   <= 1'b0;
        backoff   <= 1'b1;
        free_seen <= 1'b0;
      end
    end else if (bit_strobe) begin
      if (bit_cnt != CW'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      if (flag_slot) begin
        if (backoff) begin
          if (line_in) begin
            if (free_seen) begin
              backoff   <= 1'b0;
              free_seen <= 1'b0;
            end else begin
              free_seen <= 1'b1;
            end
          end else begin
            free_seen <= 1'b0;
          end
        end else if (!granted && req && line_in) begin
          contend <= 1'b1;
        end
      end
      if (addr_slot && contend) begin
        if (my_bit && !line_in) begin
          contend <= 1'b0;
          lost    <= 1'b1;
        end else if (pos == 3'd0) begin
          contend <= 1'b0;
          granted <= 1'b1;
        end
      end
    end
  end

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    granted && !frame_start |=> granted);

  // R7
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(granted) |-> $past(frame_start) && !$past(sw_req | frame_req));

  // R5
  lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(bit_strobe) && !$past(line_in));

  // R6
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({granted, lost}));

  // R6
  grant_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(bit_strobe));

  // R4
  wired_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe && drive_low |-> !line_in);
endmodule

// File: tb/tic_arbiter_tb.sv
`timescale 1ns/1ps
module tic_arbiter_tb;
  localparam int ARB    = (2 * 4 + 3) * 8;
  localparam int FBITS  = ARB + 8;
  localparam int FLAGSL = ARB + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, bs = 1'b0, ext_busy = 1'b0;
  logic [2:0] addr_r [3];
  logic sw_r [3];
  logic fr_r [3];
  wire  [2:0] drv, gnt, lst;
  int   tb_slot = 0;
  wire  ext_drv = ext_busy && (tb_slot == FLAGSL);
  wire  line = ~(|drv) & ~ext_drv;

  int checks = 0, fails = 0;
  bit done = 0;
  bit eg[3], el[3], eb[3], ef[3], ec[3];
  bit [2:0] mask;

  always #2 clk = ~clk;

  tic_arbiter u_dut (.clk(clk), .rst_n(rst_n), .frame_start(fs), .bit_strobe(bs), .line_in(line),
    .sw_req(sw_r[0]), .frame_req(fr_r[0]), .addr(addr_r[0]), .drive_low(drv[0]), .granted(gnt[0]), .lost(lst[0]));
  tic_arbiter u_dut_b (.clk(clk), .rst_n(rst_n), .frame_start(fs), .bit_strobe(bs), .line_in(line),
    .sw_req(sw_r[1]), .frame_req(fr_r[1]), .addr(addr_r[1]), .drive_low(drv[1]), .granted(gnt[1]), .lost(lst[1]));
  tic_arbiter u_dut_c (.clk(clk), .rst_n(rst_n), .frame_start(fs), .bit_strobe(bs), .line_in(line),
    .sw_req(sw_r[2]), .frame_req(fr_r[2]), .addr(addr_r[2]), .drive_low(drv[2]), .granted(gnt[2]), .lost(lst[2]));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int min_dev(bit [2:0] m);
    int best = -1;
    for (int d = 0; d < 3; d++)
      if (m[d] && (best < 0 || addr_r[d] < addr_r[best])) best = d;
    return best;
  endfunction

  function automatic bit ereq(int d);
    return sw_r[d] | fr_r[d];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; fs = 0; bs = 0; ext_busy = 0; tb_slot = 0;
    for (int d = 0; d < 3; d++) begin
      eg[d] = 0; el[d] = 0; eb[d] = 0; ef[d] = 0; ec[d] = 0;
      sw_r[d] = 0; fr_r[d] = 0;
    end
    repeat (3) @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      chk("R11 reset drive", drv[d], 1'b0);
      chk("R11 reset granted", gnt[d], 1'b0);
      chk("R11 reset lost", lst[d], 1'b0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 3; d++) chk("R11 idle drive", drv[d], 1'b0);
  endtask

  task automatic run_frame();
    bit exp_d[3];
    bit free, eline;
    int p;
    for (int d = 0; d < 3; d++) begin
      if (eg[d] && !ereq(d)) begin eg[d] = 0; eb[d] = 1; ef[d] = 0; end
      el[d] = 0; ec[d] = 0;
    end
    mask = '0;
    @(negedge clk); fs = 1; tb_slot = 0;
    @(negedge clk); fs = 0;
    for (int i = 0; i < FBITS; i++) begin
      tb_slot = i;
      @(negedge clk);
      p = 7 - (i - ARB);
      for (int d = 0; d < 3; d++) begin
        if (i < ARB) exp_d[d] = 0;
        else if (p == 5) exp_d[d] = eg[d];
        else if (p <= 2) exp_d[d] = ec[d] && !addr_r[d][p];
        else exp_d[d] = 0;
        if (i < ARB || (p != 5 && p > 2)) chk("R1 idle slot drive", drv[d], exp_d[d]);
        else if (p == 5) chk("R7 flag drive", drv[d], exp_d[d]);
        else chk("R4 R5 R9 address drive", drv[d], exp_d[d]);
      end
      eline = !(exp_d[0] | exp_d[1] | exp_d[2]) && !(ext_busy && i == FLAGSL);
      if (i >= ARB && p == 5) begin
        free = eline;
        for (int d = 0; d < 3; d++) begin
          if (eb[d]) begin
            if (free) begin
              if (ef[d]) begin eb[d] = 0; ef[d] = 0; end else ef[d] = 1;
            end else ef[d] = 0;
          end else if (!eg[d] && ereq(d) && free) begin
            ec[d] = 1; mask[d] = 1;
          end
        end
      end else if (i >= ARB && p <= 2) begin
        for (int d = 0; d < 3; d++)
          if (ec[d]) begin
            if (addr_r[d][p] && !eline) begin ec[d] = 0; el[d] = 1; end
            else if (p == 0) begin ec[d] = 0; eg[d] = 1; end
          end
      end
      bs = 1;
      @(negedge clk); bs = 0;
    end
    if (mask != 0) chk("R6 lowest address wins", gnt[min_dev(mask)], 1'b1);
    for (int d = 0; d < 3; d++) begin
      chk("R3 R6 R8 R10 granted", gnt[d], eg[d]);
      chk("R2 R5 lost", lst[d], el[d]);
    end
  endtask

  task automatic set_req(bit s0, bit f0, bit s1, bit f1, bit s2, bit f2);
    sw_r[0] = s0; fr_r[0] = f0; sw_r[1] = s1; fr_r[1] = f1; sw_r[2] = s2; fr_r[2] = f2;
  endtask

  task automatic random_frames(int n);
    for (int k = 0; k < n; k++) begin
      for (int d = 0; d < 3; d++) begin
        sw_r[d] = ($urandom % 3) == 0;
        fr_r[d] = ($urandom % 3) == 0;
      end
      ext_busy = ($urandom % 8) == 0;
      run_frame();
    end
    ext_busy = 0;
  endtask

  initial begin
    void'($urandom(32'h1D2C));
    addr_r[0] = 3'd5; addr_r[1] = 3'd3; addr_r[2] = 3'd7;
    do_reset();
    set_req(0,0, 0,0, 1,0); run_frame();
    chk("R9 address 7 wins alone", gnt[2], 1'b1);
    set_req(0,1, 1,0, 0,0); run_frame();
    chk("R7 R6 release and contest same frame", gnt[1], 1'b1);
    chk("R6 higher address lost", lst[0], 1'b1);
    chk("R7 released holder", gnt[2], 1'b0);
    run_frame();
    chk("R2 busy flag: no contest", lst[0], 1'b0);
    set_req(0,1, 0,0, 0,0); run_frame();
    chk("R10 loser retries", gnt[0], 1'b1);
    set_req(0,1, 1,0, 0,0); run_frame();
    chk("R8 busy restarts count", gnt[1], 1'b0);
    set_req(0,0, 1,0, 0,0); run_frame();
    chk("R8 first free frame", gnt[1], 1'b0);
    run_frame();
    chk("R8 second free frame", gnt[1], 1'b0);
    run_frame();
    chk("R8 contends after two free frames", gnt[1], 1'b1);
    set_req(0,0, 0,0, 0,0); run_frame();
    random_frames(300);
    addr_r[0] = 3'd0; addr_r[1] = 3'd6; addr_r[2] = 3'd4;
    do_reset();
    set_req(0,1, 1,0, 1,1); run_frame();
    chk("R6 address 0 beats all", gnt[0], 1'b1);
    random_frames(200);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4ns * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule